// File: doc/BRIEF.md
# Wait-for-Interrupt Wake Timer

This block puts a core to sleep on a wait request and wakes it again. It owns a free-running cycle counter and the interrupt-level field of the core's status word. A wait request always loads the supplied level into that field. If the highest pending interrupt level is already above the new level, the core keeps running. Otherwise the block enters a halted state and records the counter value at that moment.

On entering the halted state the block picks a wake count. It looks at every compare value and measures how far ahead of the counter each one lies, counting modulo 2^CW. The one that lies nearest ahead wins. With no compare closer than a full lap, the wake count is the counter minus one. The halted flag drops when the counter reaches the wake count, or when a pending level rises above the stored interrupt level. The timer wake can be left out at build time (`TIMER_EN = 0`); the block then wakes only on interrupts.

Top module: `wkt_wake_timer`

## Requirements
- R1: After a synchronous reset, count is 0, halted is 0 and int_level is 0.
- R2: count increases by exactly one on every clock edge out of reset, halted or not, and wraps modulo 2^CW.
- R3: A wait_req seen while running loads int_level with wait_level on the next edge.
- R4: A wait_req while running with pend_level greater than wait_level (unsigned) leaves halted at 0.
- R5: A wait_req while running with pend_level not greater than wait_level sets halted on the next edge, and halt_stamp equals the count seen at the request.
- R6: On halt entry, wake_count is the compare value c_i (slice i of cmp_vals, bits i*CW upward) with the smallest (c_i - count) mod 2^CW. If no distance is below (count-1 - count) mod 2^CW, wake_count is count-1. A compare equal to count has distance 0 and is chosen.
- R7: With the timer enabled, halted clears on the edge after count equals wake_count, so it stays high for (wake_count - request count) mod 2^CW cycles; 2^CW cycles when that difference is 0.
- R8: While halted, pend_level greater than int_level clears halted on the next edge; pend_level equal to int_level does not.
- R9: A wait_req while halted is ignored: int_level, wake_count, halt_stamp and halted are unchanged by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wait_req | input | 1 | One-cycle wait request |
| wait_level | input | LVL_W | New interrupt level supplied with the request |
| pend_level | input | LVL_W | Highest pending interrupt level, 0 when none |
| cmp_vals | input | NCOMP*CW | Compare values, slice i at bits i*CW upward |
| count | output | CW | Free-running cycle counter |
| int_level | output | LVL_W | Interrupt-level field of the status word |
| halted | output | 1 | Core is halted |
| wake_count | output | CW | Counter value that ends the halt |
| halt_stamp | output | CW | Counter value at halt entry |

## Verification
Every cycle, the assertions check the counter step, the level load, the halt-or-stay decision, both wake causes, the stability of the captured state while halted, and that the chosen wake count is no farther ahead than any compare. Some things need the bench's scenarios. These are the exact halt length, including the two full-lap cases (a compare equal to the count, and the count-minus-one default). They also include a compare that lies ahead only by wrapping past zero, the reset values, and a level-equal pending interrupt that must not wake the core.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
  typedef enum logic {
    WKT_RUN  = 1'b0,
    WKT_HALT = 1'b1
  } wkt_state_e;
endpackage

// File: rtl/wkt_counter.sv
module wkt_counter #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] STEP = CW'(1);

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + STEP;
  end
endmodule

// File: rtl/wkt_target_sel.sv
module wkt_target_sel #(
  parameter int CW       = 32,
  parameter int NCOMP    = 3,
  parameter bit TIMER_EN = 1'b1
) (
  input  logic [CW-1:0]       cnt,
  input  logic [NCOMP*CW-1:0] cmp_flat,
  output logic [CW-1:0]       target
);
  localparam logic [CW-1:0] STEP = CW'(1);

  // forward distance from 'from' to 'to' on the modular counter ring
  function automatic logic [CW-1:0] ring_gap(input logic [CW-1:0] to_v,
                                             input logic [CW-1:0] from_v);
    return to_v - from_v;
  endfunction

  logic [CW-1:0] chain [0:NCOMP];
  assign chain[0] = cnt - STEP;

  for (genvar g = 0; g < NCOMP; g++) begin : g_scan
    logic [CW-1:0] cand;
    assign cand = cmp_flat[g*CW +: CW];
    assign chain[g+1] = (ring_gap(cand, cnt) < ring_gap(chain[g], cnt)) ? cand : chain[g];
  end

  if (TIMER_EN) begin : g_timer
    assign target = chain[NCOMP];
  end else begin : g_no_timer
    assign target = chain[0];
  end
endmodule

// File: rtl/wkt_halt_ctl.sv
module wkt_halt_ctl #(
  parameter int CW       = 32,
  parameter int LVL_W    = 4,
  parameter bit TIMER_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wait_req,
  input  logic [LVL_W-1:0] wait_level,
  input  logic [LVL_W-1:0] pend_level,
  input  logic [CW-1:0]    cnt,
  input  logic [CW-1:0]    target,
  output logic [LVL_W-1:0] level_q,
  output logic             halted,
  output logic [CW-1:0]    wake_q,
  output logic [CW-1:0]    stamp_q,
  output logic             req_take,
  output logic             halt_go,
  output logic             irq_wake,
  output logic             tmr_wake
);
  import wkt_pkg::*;

  wkt_state_e state;

  assign halted   = (state == WKT_HALT);
  assign req_take = wait_req && !halted;
  assign halt_go  = req_take && !(pend_level > wait_level);
  assign irq_wake = halted && (pend_level > level_q);
  assign tmr_wake = TIMER_EN && halted && (cnt == wake_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= WKT_RUN;
      level_q <= '0;
      wake_q  <= '0;
      stamp_q <= '0;
    end else begin
      if (req_take) level_q <= wait_level;
      if (halt_go) begin
        state   <= WKT_HALT;
        wake_q  <= target;
        stamp_q <= cnt;
      end else if (irq_wake || tmr_wake) begin
        state <= WKT_RUN;
      end
    end
  end
endmodule

// File: rtl/wkt_wake_timer.sv
module wkt_wake_timer #(
  parameter int CW       = 32,
  parameter int NCOMP    = 3,
  parameter int LVL_W    = 4,
  parameter bit TIMER_EN = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wait_req,
  input  logic [LVL_W-1:0]    wait_level,
  input  logic [LVL_W-1:0]    pend_level,
  input  logic [NCOMP*CW-1:0] cmp_vals,
  output logic [CW-1:0]       count,
  output logic [LVL_W-1:0]    int_level,
  output logic                halted,
  output logic [CW-1:0]       wake_count,
  output logic [CW-1:0]       halt_stamp
);
  logic [CW-1:0] target;
  logic          req_take, halt_go, irq_wake, tmr_wake;

  wkt_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .cnt(count)
  );

  wkt_target_sel #(.CW(CW), .NCOMP(NCOMP), .TIMER_EN(TIMER_EN)) u_sel (
    .cnt(count), .cmp_flat(cmp_vals), .target(target)
  );

  wkt_halt_ctl #(.CW(CW), .LVL_W(LVL_W), .TIMER_EN(TIMER_EN)) u_ctl (
    .clk(clk), .rst(rst), .wait_req(wait_req), .wait_level(wait_level),
    .pend_level(pend_level), .cnt(count), .target(target),
    .level_q(int_level), .halted(halted), .wake_q(wake_count),
    .stamp_q(halt_stamp), .req_take(req_take), .halt_go(halt_go),
    .irq_wake(irq_wake), .tmr_wake(tmr_wake)
  );
endmodule

// File: rtl/wkt_checker.sv
module wkt_checker #(
  parameter int CW       = 32,
  parameter int NCOMP    = 3,
  parameter int LVL_W    = 4,
  parameter bit TIMER_EN = 1'b1
) (
  input logic                clk,
  input logic                rst,
  input logic                wait_req,
  input logic [LVL_W-1:0]    wait_level,
  input logic [LVL_W-1:0]    pend_level,
  input logic [NCOMP*CW-1:0] cmp_vals,
  input logic [CW-1:0]       count,
  input logic [LVL_W-1:0]    int_level,
  input logic                halted,
  input logic [CW-1:0]       wake_count,
  input logic [CW-1:0]       halt_stamp,
  input logic [CW-1:0]       target,
  input logic                halt_go
);
  localparam logic [CW-1:0] STEP = CW'(1);

  assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> count == $past(count) + STEP);

  assert_level_load_R3: assert property (@(posedge clk) disable iff (rst)
    (wait_req && !halted) |=> int_level == $past(wait_level));

  assert_no_halt_pending_R4: assert property (@(posedge clk) disable iff (rst)
    (wait_req && !halted && pend_level > wait_level) |=> !halted);

  assert_halt_entry_R5: assert property (@(posedge clk) disable iff (rst)
    (wait_req && !halted && !(pend_level > wait_level))
      |=> halted && halt_stamp == $past(count));

  assert_timer_wake_R7: assert property (@(posedge clk) disable iff (rst)
    (TIMER_EN && halted && count == wake_count) |=> !halted);

  assert_irq_wake_R8: assert property (@(posedge clk) disable iff (rst)
    (halted && pend_level > int_level) |=> !halted);

  assert_hold_while_halted_R9: assert property (@(posedge clk) disable iff (rst)
    (halted && !(pend_level > int_level) && !(TIMER_EN && count == wake_count))
      |=> halted && $stable(int_level) && $stable(wake_count) && $stable(halt_stamp));

  // R6: the chosen target is no farther ahead than any compare value
  always @(posedge clk) begin
    if (!rst && halt_go && TIMER_EN) begin
      for (int i = 0; i < NCOMP; i++) begin
        assert_nearest_R6: assert ((cmp_vals[i*CW +: CW] - count) >= (target - count))
          else $error("nearest-target violation at compare %0d", i);
      end
    end
  end
endmodule

bind wkt_wake_timer wkt_checker #(.CW(CW), .NCOMP(NCOMP), .LVL_W(LVL_W), .TIMER_EN(TIMER_EN)) u_chk (
  .clk(clk), .rst(rst), .wait_req(wait_req), .wait_level(wait_level),
  .pend_level(pend_level), .cmp_vals(cmp_vals), .count(count),
  .int_level(int_level), .halted(halted), .wake_count(wake_count),
  .halt_stamp(halt_stamp), .target(target), .halt_go(halt_go)
);

// File: tb/wkt_wake_timer_test.sv
module wkt_wake_timer_test;
  localparam int PERIOD = 10;
  localparam int CW     = 10;
  localparam int NCOMP  = 3;
  localparam int LVL_W  = 4;
  localparam int RING   = 1 << CW;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                wait_req = 1'b0;
  logic [LVL_W-1:0]    wait_level = '0;
  logic [LVL_W-1:0]    pend_level = '0;
  logic [NCOMP*CW-1:0] cmp_vals = '0;
  logic [CW-1:0]       count, wake_count, halt_stamp;
  logic [LVL_W-1:0]    int_level;
  logic                halted;

  int total = 0;
  int bad   = 0;

  wkt_wake_timer #(.CW(CW), .NCOMP(NCOMP), .LVL_W(LVL_W), .TIMER_EN(1'b1)) uut (
    .clk(clk), .rst(rst), .wait_req(wait_req), .wait_level(wait_level),
    .pend_level(pend_level), .cmp_vals(cmp_vals), .count(count),
    .int_level(int_level), .halted(halted), .wake_count(wake_count),
    .halt_stamp(halt_stamp)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wrap(input int v);
    return ((v % RING) + RING) % RING;
  endfunction

  // independent model of the wake choice: smallest lap-relative lead
  function automatic int model_wake(input int c, input int a, input int b, input int d);
    int vals [3];
    int best, best_lead;
    vals = '{a, b, d};
    best = wrap(c - 1);
    best_lead = RING - 1;
    foreach (vals[k]) begin
      if (wrap(vals[k] - c) < best_lead) begin
        best_lead = wrap(vals[k] - c);
        best = vals[k];
      end
    end
    return best;
  endfunction

  task automatic set_cmps(input int a, input int b, input int d);
    cmp_vals = {CW'(wrap(d)), CW'(wrap(b)), CW'(wrap(a))};
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // issue a one-cycle request; returns the count seen at the request edge
  task automatic request(input int lvl, output int c);
    c = count;
    wait_req = 1'b1;
    wait_level = LVL_W'(lvl);
    step(1);
    wait_req = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    step(2);
    check("R1 count", count, 0);
    check("R1 halted", halted, 0);
    check("R1 int_level", int_level, 0);
    rst = 1'b0;
  endtask

  task automatic t_counting;
    int c0;
    c0 = count;
    step(37);
    check("R2 step", count, wrap(c0 + 37));
  endtask

  task automatic t_pending_blocks;
    int c;
    set_cmps(count + 100, count + 200, count + 300);
    pend_level = 4'd5;
    request(3, c);
    check("R3 level load", int_level, 3);
    check("R4 no halt", halted, 0);
    step(2);
    check("R4 still running", halted, 0);
    pend_level = '0;
  endtask

  task automatic t_nearest;
    int c, w;
    set_cmps(count + 50, count + 20, count + 300);
    request(2, c);
    w = model_wake(c, wrap(c + 50), wrap(c + 20), wrap(c + 300));
    check("R5 halted", halted, 1);
    check("R5 stamp", halt_stamp, c);
    check("R6 nearest", wake_count, w);
    step(19);
    check("R7 still halted", halted, 1);
    step(1);
    check("R7 woke", halted, 0);
    check("R2 count after wake", count, wrap(c + 21));
  endtask

  task automatic t_wrap_lead;
    int c, w;
    // lead of 1000 crosses zero for most starting counts
    set_cmps(count + 1000, count + 1010, count + 1020);
    request(1, c);
    w = model_wake(c, wrap(c + 1000), wrap(c + 1010), wrap(c + 1020));
    check("R6 wrapped lead", wake_count, w);
    check("R6 wrapped lead value", wake_count, wrap(c + 1000));
    step(999);
    check("R7 wrapped still halted", halted, 1);
    step(1);
    check("R7 wrapped woke", halted, 0);
  endtask

  task automatic t_default_lap;
    int c;
    set_cmps(count - 1, count - 1, count - 1);
    request(0, c);
    check("R6 default count-1", wake_count, wrap(c - 1));
    step(RING - 2);
    check("R7 default lap halted", halted, 1);
    step(1);
    check("R7 default lap woke", halted, 0);
  endtask

  task automatic t_equal_count;
    int c;
    set_cmps(count + 500, count, count + 700);
    request(0, c);
    check("R6 equal compare chosen", wake_count, c);
    step(RING - 1);
    check("R7 full lap halted", halted, 1);
    step(1);
    check("R7 full lap woke", halted, 0);
  endtask

  task automatic t_irq_and_ignore;
    int c, w0, s0;
    set_cmps(count + 600, count + 700, count + 800);
    pend_level = 4'd3;
    request(3, c);
    check("R5 equal pending halts", halted, 1);
    w0 = wake_count;
    s0 = halt_stamp;
    step(4);
    check("R8 equal pending no wake", halted, 1);
    wait_req = 1'b1;
    wait_level = 4'd1;
    step(1);
    wait_req = 1'b0;
    check("R9 level kept", int_level, 3);
    check("R9 wake kept", wake_count, w0);
    check("R9 stamp kept", halt_stamp, s0);
    check("R9 still halted", halted, 1);
    pend_level = 4'd4;
    step(1);
    check("R8 irq wake", halted, 0);
    pend_level = '0;
  endtask

  initial begin
    #(PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(1);
    t_reset();
    t_counting();
    t_pending_blocks();
    t_nearest();
    t_wrap_lead();
    t_default_lap();
    t_equal_count();
    t_irq_and_ignore();
    t_counting();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule